// File: doc/BRIEF.md
# Watchdog Timer with Frequency Rollback

This block guards a programmable clock source against a bad frequency choice. Software loads a timeout code, and the block then counts whole seconds on a one-cycle timebase tick. If software does not refresh the timer in time, the block sets an alarm flag. It issues a fixed-length active-low reset pulse on a shared pin and replaces the active frequency selection with a safe one. Software refreshes the timer by rewriting the timeout code.

The safe selection is chosen by a rollback bit. With the bit at 0 the block returns to the hardware strap setting. With the bit at 1 it returns to the software setting that was in force before the last software write, which is the one that most likely caused the hang. A one-deep history register keeps that earlier value.

The shared pin has two modes. It can be a power-down input or a reset output, and the reset pulse only reaches the pin in output mode.

Top module: `wdt_freq_revert`

## Requirements
- R1: After a control write with timeout code N, where 1 <= N <= MAX_CODE (10 by default), the watchdog expires on the Nth tick. `alarm_o` and control bit 6 become 1 on the clock edge that samples that tick, and not on any earlier tick.
- R2: Code 0 and codes above MAX_CODE (11 to 15) disable the watchdog. No number of ticks sets the alarm.
- R3: The alarm stays at 1 until a control write carries timeout code 0, and that write clears it. Rewriting a non-zero code leaves the alarm set.
- R4: Any control write with a valid non-zero code restarts the seconds count from zero.
- R5: `freq_o` equals `strap_i` until software writes the frequency register (address 1, bits FSEL_W-1:0). After each such write, `freq_o` equals the written value.
- R6: On expiry with rollback bit 4 at 0, `freq_o` returns to `strap_i`.
- R7: On expiry with rollback bit 4 at 1, `freq_o` becomes the selection that was active just before the most recent software frequency write.
- R8: In output mode (control bit 7 = 0), `pin_oe_o` is 1, and `pin_o` goes low on the expiry edge and stays low for exactly RST_PULSE_CYC cycles. In input mode (bit 7 = 1), `pin_oe_o` is 0, `pin_o` stays high, and `pwr_down_o` is the inverse of `pin_i`.
- R9: Test bit 5 reads back as written and does not change the timeout behaviour.
- R10: After reset, the control register reads 0x80 (code, rollback, test and alarm all 0; mode 1), `pin_o` is high and `freq_o` follows `strap_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control register, 1 = frequency register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| tick_i | input | 1 | One-second timebase pulse, one cycle wide |
| strap_i | input | FSEL_W | Hardware strap frequency selection |
| freq_o | output | FSEL_W | Active frequency selection |
| alarm_o | output | 1 | Watchdog alarm flag |
| pin_i | input | 1 | Shared pin input value |
| pin_o | output | 1 | Shared pin output value (active-low reset) |
| pin_oe_o | output | 1 | Shared pin output enable |
| pwr_down_o | output | 1 | Power-down request taken from the pin in input mode |

## Verification
The bench keeps the default MAX_CODE of 10 and FSEL_W of 4, and it sets RST_PULSE_CYC to 4. The tick is a pulse that the bench drives itself, so the longest timeout of ten seconds takes only ten pulses. This lets the bench cover the codes at both edges of the valid range, the invalid codes above it, and refresh at the last tick before expiry. The short pulse lets the bench measure the exact reset pulse length, and the 4-bit selection lets it use distinct strap, current and history values so that each rollback path can be told apart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CODE_W = 4;

  localparam int BIT_REVERT = 4;
  localparam int BIT_TEST   = 5;
  localparam int BIT_ALARM  = 6;
  localparam int BIT_MODE   = 7;

  typedef struct packed {
    logic                pin_in_mode;
    logic                test;
    logic                revert;
    logic [CODE_W-1:0]   code;
  } ctrl_t;
endpackage

// File: rtl/wdt_sec_timer.sv
module wdt_sec_timer #(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tick_i,
  output logic              expire_o
);
  logic              running_q;
  logic [CODE_W-1:0] limit_q, cnt_q;
  logic              code_ok, last_sec;

  assign code_ok  = (code_i != '0) && (code_i <= CODE_W'(MAX_CODE));
  assign last_sec = (cnt_q == limit_q - 1'b1);
  assign expire_o = running_q && tick_i && !load_i && last_sec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      limit_q   <= '0;
      cnt_q     <= '0;
    end else if (load_i) begin
      running_q <= code_ok;
      limit_q   <= code_i;
      cnt_q     <= '0;
    end else if (running_q && tick_i) begin
      if (last_sec) begin
        running_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_freq_hist.sv
module wdt_freq_hist #(
  parameter int FSEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FSEL_W-1:0] strap_i,
  input  logic              wr_i,
  input  logic [FSEL_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic              revert_i,
  output logic [FSEL_W-1:0] freq_o
);
  logic              sw_valid_q;
  logic [FSEL_W-1:0] sw_q, hist_q;

  assign freq_o = sw_valid_q ? sw_q : strap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_valid_q <= 1'b0;
      sw_q       <= '0;
      hist_q     <= '0;
    end else if (wr_i) begin
      hist_q     <= freq_o;  // keep the setting being replaced
      sw_q       <= wdata_i;
      sw_valid_q <= 1'b1;
    end else if (expire_i) begin
      if (revert_i) begin
        sw_q       <= hist_q;
        sw_valid_q <= 1'b1;
      end else begin
        sw_valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int RST_PULSE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int PW = $clog2(RST_PULSE_CYC + 1);
  logic [PW-1:0] cnt_q;

  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start_i)  cnt_q <= PW'(RST_PULSE_CYC);
    else if (active_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_freq_revert.sv
module wdt_freq_revert #(
  parameter int FSEL_W        = 4,
  parameter int MAX_CODE      = 10,
  parameter int RST_PULSE_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  input  logic [FSEL_W-1:0] strap_i,
  output logic [FSEL_W-1:0] freq_o,
  output logic              alarm_o,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              pwr_down_o
);
  import wdt_pkg::*;

  ctrl_t ctrl_q;
  logic  alarm_q, ctrl_wr, freq_wr, expire, pulse_active;
  logic  unused_wdata;

  assign ctrl_wr      = wr_en_i && !addr_i;
  assign freq_wr      = wr_en_i && addr_i;
  assign unused_wdata = wdata_i[BIT_ALARM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{pin_in_mode: 1'b1, test: 1'b0, revert: 1'b0, code: '0};
      alarm_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.pin_in_mode <= wdata_i[BIT_MODE];
        ctrl_q.test        <= wdata_i[BIT_TEST];
        ctrl_q.revert      <= wdata_i[BIT_REVERT];
        ctrl_q.code        <= wdata_i[CODE_W-1:0];
      end
      if (ctrl_wr && wdata_i[CODE_W-1:0] == '0) alarm_q <= 1'b0;
      else if (expire)                           alarm_q <= 1'b1;
    end
  end

  wdt_sec_timer #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ctrl_wr),
    .code_i   (wdata_i[CODE_W-1:0]),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  wdt_freq_hist #(.FSEL_W(FSEL_W)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_i  (strap_i),
    .wr_i     (freq_wr),
    .wdata_i  (wdata_i[FSEL_W-1:0]),
    .expire_i (expire),
    .revert_i (ctrl_q.revert),
    .freq_o   (freq_o)
  );

  wdt_rst_pulse #(.RST_PULSE_CYC(RST_PULSE_CYC)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (expire),
    .active_o (pulse_active)
  );

  assign alarm_o    = alarm_q;
  assign pin_oe_o   = !ctrl_q.pin_in_mode;
  assign pin_o      = !(pulse_active && !ctrl_q.pin_in_mode);
  assign pwr_down_o = ctrl_q.pin_in_mode && !pin_i;

  always_comb begin
    rdata_o = '0;
    if (addr_i) begin
      rdata_o[FSEL_W-1:0] = freq_o;
    end else begin
      rdata_o[CODE_W-1:0] = ctrl_q.code;
      rdata_o[BIT_REVERT] = ctrl_q.revert;
      rdata_o[BIT_TEST]   = ctrl_q.test;
      rdata_o[BIT_ALARM]  = alarm_q;
      rdata_o[BIT_MODE]   = ctrl_q.pin_in_mode;
    end
  end
endmodule

// File: rtl/wdt_freq_revert_chk.sv
module wdt_freq_revert_chk #(
  parameter int FSEL_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              addr_i,
  input logic [7:0]        wdata_i,
  input logic              tick_i,
  input logic [FSEL_W-1:0] strap_i,
  input logic [FSEL_W-1:0] freq_o,
  input logic              alarm_o,
  input logic              pin_o
);
  p_alarm_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[3:0] == 4'd0) |=> !alarm_o);

  p_alarm_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !(wr_en_i && !addr_i && wdata_i[3:0] == 4'd0)) |=> alarm_o);

  p_alarm_needs_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_o && !tick_i) |=> !alarm_o);

  p_pulse_with_alarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_o) |-> alarm_o);

  p_freq_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && addr_i) && !tick_i) |=> ($stable(freq_o) || !$stable(strap_i)));
endmodule

bind wdt_freq_revert wdt_freq_revert_chk #(.FSEL_W(FSEL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick_i  (tick_i),
  .strap_i (strap_i),
  .freq_o  (freq_o),
  .alarm_o (alarm_o),
  .pin_o   (pin_o)
);

// File: tb/wdt_freq_revert_tb.sv
module wdt_freq_revert_tb_top;
  localparam int FSEL_W = 4;
  localparam int PULSE  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0, tick = 1'b0, pin_in = 1'b1;
  logic [7:0] wdata = '0, rdata;
  logic [FSEL_W-1:0] strap = 4'd5, freq;
  logic alarm, pin_out, pin_oe, pwr_down;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wdt_freq_revert #(.FSEL_W(FSEL_W), .MAX_CODE(10), .RST_PULSE_CYC(PULSE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .strap_i(strap), .freq_o(freq), .alarm_o(alarm),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .pwr_down_o(pwr_down));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic read_ctrl(output logic [7:0] v);
    addr = 1'b0; #1 v = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    read_ctrl(v);
    check(v == 8'h80, "R10 ctrl", v, 8'h80);
    check(pin_out == 1'b1, "R10 pin", pin_out, 1);
    check(freq == strap, "R10/R5 freq=strap", freq, strap);
  endtask

  task automatic t_disabled;
    wr(0, 8'h00); ticks(12);
    check(!alarm, "R2 code0", alarm, 0);
    wr(0, 8'h0B); ticks(12);
    check(!alarm, "R2 code11", alarm, 0);
    wr(0, 8'h0F); ticks(16);
    check(!alarm, "R2 code15", alarm, 0);
  endtask

  task automatic t_timeout(input int n);
    int lows = 0;
    wr(0, 8'(n)); ticks(n - 1);
    check(!alarm, "R1 before last tick", alarm, 0);
    check(pin_oe == 1'b1, "R8 oe in output mode", pin_oe, 1);
    ticks(1);
    check(alarm, "R1 alarm at tick N", alarm, 1);
    while (!pin_out && lows < 50) begin lows++; @(negedge clk); end
    check(lows == PULSE, "R8 pulse length", lows, PULSE);
    wr(0, 8'(n));
    check(alarm, "R3 nonzero rewrite keeps alarm", alarm, 1);
    wr(0, 8'h00);
    check(!alarm, "R3 clear by code0", alarm, 0);
  endtask

  task automatic t_refresh;
    wr(0, 8'h03); ticks(2);
    wr(0, 8'h03); ticks(2);
    check(!alarm, "R4 refresh restarts count", alarm, 0);
    ticks(1);
    check(alarm, "R4 expiry after refresh", alarm, 1);
    wr(0, 8'h00);
  endtask

  task automatic t_freq;
    wr(1, 8'h09);
    check(freq == 4'd9, "R5 sw write", freq, 9);
    wr(1, 8'h0C);
    check(freq == 4'd12, "R5 second write", freq, 12);
    wr(0, 8'h02); ticks(2);
    check(freq == strap, "R6 revert to strap", freq, strap);
    wr(0, 8'h00);
    wr(1, 8'h07); wr(1, 8'h02);
    check(freq == 4'd2, "R5 latest write", freq, 2);
    wr(0, 8'h12); ticks(2);
    check(freq == 4'd7, "R7 revert to previous", freq, 7);
    wr(0, 8'h00);
  endtask

  task automatic t_test_bit;
    logic [7:0] v;
    wr(0, 8'h22);
    read_ctrl(v);
    check(v[5] == 1'b1, "R9 test readback", v[5], 1);
    ticks(1);
    check(!alarm, "R9 no early expiry", alarm, 0);
    ticks(1);
    check(alarm, "R9 normal expiry", alarm, 1);
    wr(0, 8'h00);
  endtask

  task automatic t_input_mode;
    int lows = 0;
    wr(0, 8'h81);
    check(pin_oe == 1'b0, "R8 oe off in input mode", pin_oe, 0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check(alarm, "R8 alarm in input mode", alarm, 1);
    for (int i = 0; i < PULSE + 2; i++) begin
      if (!pin_out) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R8 pin high in input mode", lows, 0);
    pin_in = 1'b0; #1;
    check(pwr_down == 1'b1, "R8 power-down follows pin", pwr_down, 1);
    pin_in = 1'b1; #1;
    check(pwr_down == 1'b0, "R8 power-down released", pwr_down, 0);
    wr(0, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_timeout(1);
        t_timeout(3);
        t_timeout(10);
        t_refresh();
        t_freq();
        t_test_bit();
        t_input_mode();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule